// File: doc/BRIEF.md
# GPIO Port with Interrupt Sensing

This block is a 32-pin general-purpose I/O port that sits behind a small memory-mapped register bus. Software sets the value each pin drives and chooses, pin by pin, whether that pin is an output. It can read the synchronized level of every pad at any time. The pad-facing side is three plain vectors: `pad_in`, `pad_out` and `pad_oe`. Tri-state buffers and pin multiplexing are outside this block.

Every pin also has an interrupt sense code of two bits. The code selects one of four conditions: low level, high level, rising edge or falling edge. Pad levels first pass through a two-flop synchronizer. An edge is found by comparing the synchronized level with a copy of it delayed by one cycle. When a pin's condition is met, its sticky status bit is set, whatever the mask says. Software clears a status bit by writing a one to it. A single interrupt line is raised whenever a status bit and the matching mask bit are both set.

The bus is single-cycle for writes. A read returns its data from a register in the cycle after the read strobe, and that value is held until the next read.

Top module: `gpio_sense_port`

## Requirements
- R1: Writing offset 0x00 sets the output data register, and `pad_out` equals it. Writing offset 0x04 sets the direction register, and `pad_oe` equals it (1 = output, 0 = input). Both registers read back at their own offsets.
- R2: A read at offset 0x08 returns `pad_in` after a two-flop synchronizer, for every pin and whatever its direction. A write to 0x08 changes nothing.
- R3: The sense code of pin n is held in offset 0x0C for pins 0–15 and in offset 0x10 for pins 16–31. It occupies bits [2*(n mod 16)+1 : 2*(n mod 16)].
- R4: Code 0 (low level) and code 1 (high level) set the status bit on every cycle in which the synchronized level is active. While the level stays active, the bit cannot be cleared.
- R5: Code 2 (rising) and code 3 (falling) set the status bit once for each edge of the synchronized level. Suppose the pad changes before clock edge k. Then the status bit is visible after edge k+2. A level that is held does not set the bit again.
- R6: Writing offset 0x18 clears each status bit written as 1 and leaves bits written as 0 unchanged. If a set condition and a clear fall in the same cycle, the set wins.
- R7: Status bits are set whether or not the pin is masked. `irq` is high exactly when any bit of (status AND mask, offset 0x14) is set. A mask bit of 1 enables the pin.
- R8: After reset, every register is zero: data, direction, both sense registers, mask and status. `irq` is low.
- R9: Reads of unmapped offsets return zero, and writes to them change nothing. Unmapped means 0x1C–0x1F and any address whose two low bits are not zero.
- R10: `bus_rdata` is updated in the cycle after `bus_re` is high, with the register contents from before any write in that same cycle. It holds its value while `bus_re` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | AW | Byte address of the access |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data |
| pad_in | input | 32 | Raw pad levels |
| pad_out | output | 32 | Output data to the pads |
| pad_oe | output | 32 | Per-pin output enable |
| irq | output | 1 | Combined masked interrupt |

## Verification
Some properties are checked on every cycle by assertions:
- a status bit rises only in a cycle after its detector fired;
- a status bit falls only after a write of one to it;
- a firing detector wins over a same-cycle clear;
- `irq` is never high with a zero mask;
- unmapped reads return zero;
- `pad_oe` changes only after a direction write.

Other behaviour needs the bench's scenarios, which compare the ports against a reference model on every cycle:
- the placement of sense fields;
- the three-edge latency from pad to status;
- one set per edge against a set on every cycle at a held level;
- the clear being refused while a level persists.

// File: rtl/gpio_sense_pkg.sv
package gpio_sense_pkg;

    localparam int REG_W        = 32;
    localparam int SENSE_W      = 2;
    localparam int PINS_PER_CFG = REG_W / SENSE_W;

    localparam logic [7:0] OFS_DOUT = 8'h00;
    localparam logic [7:0] OFS_DIR  = 8'h04;
    localparam logic [7:0] OFS_PAD  = 8'h08;
    localparam logic [7:0] OFS_CFGL = 8'h0C;
    localparam logic [7:0] OFS_CFGH = 8'h10;
    localparam logic [7:0] OFS_MASK = 8'h14;
    localparam logic [7:0] OFS_STAT = 8'h18;

    typedef enum logic [SENSE_W-1:0] {
        SENSE_LOW  = 2'd0,
        SENSE_HIGH = 2'd1,
        SENSE_RISE = 2'd2,
        SENSE_FALL = 2'd3
    } sense_e;

    typedef enum logic [2:0] {
        SEL_DOUT,
        SEL_DIR,
        SEL_PAD,
        SEL_CFGL,
        SEL_CFGH,
        SEL_MASK,
        SEL_STAT,
        SEL_NONE
    } reg_sel_e;

    function automatic reg_sel_e decode_ofs(input logic [7:0] ofs);
        reg_sel_e sel;
        case (ofs)
            OFS_DOUT: sel = SEL_DOUT;
            OFS_DIR:  sel = SEL_DIR;
            OFS_PAD:  sel = SEL_PAD;
            OFS_CFGL: sel = SEL_CFGL;
            OFS_CFGH: sel = SEL_CFGH;
            OFS_MASK: sel = SEL_MASK;
            OFS_STAT: sel = SEL_STAT;
            default:  sel = SEL_NONE;
        endcase
        return sel;
    endfunction

endpackage

// File: rtl/gpio_pad_sync.sv
module gpio_pad_sync #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pad_i,
    output logic [W-1:0] lvl_o,
    output logic [W-1:0] prev_o
);

    logic [W-1:0] meta_q;

    // Two flops for metastability, a third to hold last cycle's level
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            lvl_o  <= '0;
            prev_o <= '0;
        end else begin
            meta_q <= pad_i;
            lvl_o  <= meta_q;
            prev_o <= lvl_o;
        end
    end

endmodule

// File: rtl/gpio_sense_detect.sv
module gpio_sense_detect
    import gpio_sense_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0]         lvl_i,
    input  logic [W-1:0]         prev_i,
    input  logic [SENSE_W*W-1:0] cfg_i,
    output logic [W-1:0]         hit_o
);

    for (genvar g = 0; g < W; g++) begin : g_pin
        sense_e code;
        logic   pin_hit;

        assign code = sense_e'(cfg_i[SENSE_W*g +: SENSE_W]);

        always_comb begin
            unique case (code)
                SENSE_LOW:  pin_hit = ~lvl_i[g];
                SENSE_HIGH: pin_hit =  lvl_i[g];
                SENSE_RISE: pin_hit =  lvl_i[g] & ~prev_i[g];
                SENSE_FALL: pin_hit = ~lvl_i[g] &  prev_i[g];
                default:    pin_hit = 1'b0;
            endcase
        end

        assign hit_o[g] = pin_hit;
    end

endmodule

// File: rtl/gpio_irq_status.sv
module gpio_irq_status #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] stat_o
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stat_o <= '0;
        end else begin
            stat_o <= (stat_o & ~clr_i) | set_i;
        end
    end

    AST_NO_SPURIOUS_SET: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((stat_o & ~$past(stat_o) & ~$past(set_i)) == '0)); // R4

    AST_CLEAR_ONLY_BY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((~stat_o & $past(stat_o) & ~$past(clr_i)) == '0)); // R6

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (|set_i) |=> ((stat_o & $past(set_i)) == $past(set_i))); // R6

endmodule

// File: rtl/gpio_sense_port.sv
module gpio_sense_port
    import gpio_sense_pkg::*;
#(
    parameter int AW = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [AW-1:0]    bus_addr,
    input  logic [REG_W-1:0] bus_wdata,
    input  logic             bus_we,
    input  logic             bus_re,
    output logic [REG_W-1:0] bus_rdata,
    input  logic [REG_W-1:0] pad_in,
    output logic [REG_W-1:0] pad_out,
    output logic [REG_W-1:0] pad_oe,
    output logic             irq
);

    localparam int PINS  = REG_W;
    localparam int CFG_W = SENSE_W * PINS;

    logic [REG_W-1:0] dout_q;
    logic [REG_W-1:0] dir_q;
    logic [REG_W-1:0] cfgl_q;
    logic [REG_W-1:0] cfgh_q;
    logic [REG_W-1:0] mask_q;
    logic [REG_W-1:0] stat_w;
    logic [PINS-1:0]  lvl_w;
    logic [PINS-1:0]  prev_w;
    logic [PINS-1:0]  hit_w;
    logic [PINS-1:0]  clr_w;
    logic [CFG_W-1:0] cfg_all;
    logic [REG_W-1:0] rd_mux;
    reg_sel_e         sel;

    assign sel = decode_ofs(8'(bus_addr));

    // Register writes
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dout_q <= '0;
            dir_q  <= '0;
            cfgl_q <= '0;
            cfgh_q <= '0;
            mask_q <= '0;
        end else if (bus_we) begin
            unique case (sel)
                SEL_DOUT: dout_q <= bus_wdata;
                SEL_DIR:  dir_q  <= bus_wdata;
                SEL_CFGL: cfgl_q <= bus_wdata;
                SEL_CFGH: cfgh_q <= bus_wdata;
                SEL_MASK: mask_q <= bus_wdata;
                default:  ;
            endcase
        end
    end

    assign clr_w   = (bus_we && sel == SEL_STAT) ? bus_wdata : '0;
    assign cfg_all = {cfgh_q, cfgl_q};

    gpio_pad_sync #(.W(PINS)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pad_i  (pad_in),
        .lvl_o  (lvl_w),
        .prev_o (prev_w)
    );

    gpio_sense_detect #(.W(PINS)) u_detect (
        .lvl_i  (lvl_w),
        .prev_i (prev_w),
        .cfg_i  (cfg_all),
        .hit_o  (hit_w)
    );

    gpio_irq_status #(.W(PINS)) u_status (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (hit_w),
        .clr_i  (clr_w),
        .stat_o (stat_w)
    );

    // Read path
    always_comb begin
        unique case (sel)
            SEL_DOUT: rd_mux = dout_q;
            SEL_DIR:  rd_mux = dir_q;
            SEL_PAD:  rd_mux = lvl_w;
            SEL_CFGL: rd_mux = cfgl_q;
            SEL_CFGH: rd_mux = cfgh_q;
            SEL_MASK: rd_mux = mask_q;
            SEL_STAT: rd_mux = stat_w;
            default:  rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bus_rdata <= '0;
        end else if (bus_re) begin
            bus_rdata <= rd_mux;
        end
    end

    assign pad_out = dout_q;
    assign pad_oe  = dir_q;
    assign irq     = |(stat_w & mask_q);

    AST_IRQ_NEEDS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (mask_q != '0)); // R7

    AST_UNMAPPED_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_re && sel == SEL_NONE) |=> (bus_rdata == '0)); // R9

    AST_OE_ONLY_BY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_we && sel == SEL_DIR) |=> $stable(pad_oe)); // R1

endmodule

// File: tb/tb_gpio_sense_port.sv
module tb_gpio_sense_port;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic        we = 1'b0;
    logic        re = 1'b0;
    logic [31:0] rd_data;
    logic [31:0] pad_in = '0;
    logic [31:0] pad_out;
    logic [31:0] pad_oe;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    bit running = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio_sense_port #(.AW(5)) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (addr),
        .bus_wdata (wdata),
        .bus_we    (we),
        .bus_re    (re),
        .bus_rdata (rd_data),
        .pad_in    (pad_in),
        .pad_out   (pad_out),
        .pad_oe    (pad_oe),
        .irq       (irq)
    );

    // ---------------- reference model ----------------
    logic [31:0] m_dout, m_dir, m_cfgl, m_cfgh, m_mask, m_stat, m_rd;
    logic [31:0] m_s1, m_lvl, m_prev;

    always @(posedge clk) begin
        logic [31:0] cond;
        logic [31:0] clr;
        int code;
        if (!rst_n) begin
            m_dout = 0; m_dir = 0; m_cfgl = 0; m_cfgh = 0; m_mask = 0;
            m_stat = 0; m_rd = 0; m_s1 = 0; m_lvl = 0; m_prev = 0;
        end else begin
            for (int i = 0; i < 32; i++) begin
                code = (i < 16) ? int'((m_cfgl >> (2*i)) & 3) : int'((m_cfgh >> (2*(i-16))) & 3);
                if (code == 0)      cond[i] = !m_lvl[i];
                else if (code == 1) cond[i] = m_lvl[i];
                else if (code == 2) cond[i] = m_lvl[i] && !m_prev[i];
                else                cond[i] = !m_lvl[i] && m_prev[i];
            end
            clr = (we && addr == 5'h18) ? wdata : 32'h0;
            if (re) begin
                if      (addr == 5'h00) m_rd = m_dout;
                else if (addr == 5'h04) m_rd = m_dir;
                else if (addr == 5'h08) m_rd = m_lvl;
                else if (addr == 5'h0C) m_rd = m_cfgl;
                else if (addr == 5'h10) m_rd = m_cfgh;
                else if (addr == 5'h14) m_rd = m_mask;
                else if (addr == 5'h18) m_rd = m_stat;
                else                    m_rd = 0;
            end
            m_stat = (m_stat & ~clr) | cond;
            if (we) begin
                if      (addr == 5'h00) m_dout = wdata;
                else if (addr == 5'h04) m_dir  = wdata;
                else if (addr == 5'h0C) m_cfgl = wdata;
                else if (addr == 5'h10) m_cfgh = wdata;
                else if (addr == 5'h14) m_mask = wdata;
            end
            m_prev = m_lvl;
            m_lvl  = m_s1;
            m_s1   = pad_in;
        end
    end

    task automatic expect32(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && running) begin
            expect32("R1 pad_out vs model", pad_out, m_dout);
            expect32("R1 pad_oe vs model", pad_oe, m_dir);
            expect32("R7 irq vs model", {31'b0, irq}, {31'b0, |(m_stat & m_mask)});
            expect32("R10 rdata vs model", rd_data, m_rd);
        end
    end

    // ---------------- bus tasks ----------------
    task automatic bus_write(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wdata = d; we = 1'b1;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic bus_read(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk);
        addr = a; re = 1'b1;
        @(negedge clk);
        re = 1'b0;
        d = rd_data;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    // ---------------- directed scenarios ----------------
    initial begin
        logic [31:0] d;
        idle(3);
        @(negedge clk);
        rst_n = 1'b1;
        running = 1'b1;

        // R8: reset state
        expect32("R8 irq after reset", {31'b0, irq}, 32'h0);
        expect32("R8 pad_oe after reset", pad_oe, 32'h0);
        bus_read(5'h14, d); expect32("R8 mask reset", d, 32'h0);
        bus_read(5'h0C, d); expect32("R8 cfg low reset", d, 32'h0);
        bus_read(5'h00, d); expect32("R8 data reset", d, 32'h0);
        idle(4);
        bus_read(5'h18, d); expect32("R4 low-level default sets all", d, 32'hFFFF_FFFF);

        // R1: data and direction
        bus_write(5'h00, 32'hA5A5_0F0F);
        bus_write(5'h04, 32'hFFFF_0000);
        expect32("R1 pad_out", pad_out, 32'hA5A5_0F0F);
        expect32("R1 pad_oe", pad_oe, 32'hFFFF_0000);
        bus_read(5'h04, d); expect32("R1 dir readback", d, 32'hFFFF_0000);
        // R10: held while re low
        idle(2);
        expect32("R10 rdata held", rd_data, 32'hFFFF_0000);

        // R4 / R6: high level, clear refused while active
        bus_write(5'h0C, 32'h5555_5555);
        bus_write(5'h10, 32'h5555_5555);
        bus_write(5'h18, 32'hFFFF_FFFF);
        bus_read(5'h18, d); expect32("R6 clear all", d, 32'h0);
        pad_in = 32'h0000_0008;
        idle(4);
        bus_read(5'h18, d); expect32("R4 high level sets pin 3", d, 32'h0000_0008);
        bus_write(5'h18, 32'h0000_0008);
        bus_read(5'h18, d); expect32("R6 set wins over clear", d, 32'h0000_0008);
        pad_in = 32'h0;
        idle(4);
        bus_write(5'h18, 32'h0000_0008);
        bus_read(5'h18, d); expect32("R6 clear after level drops", d, 32'h0);

        // R2: pad status, write ignored
        pad_in = 32'h1234_5678;
        idle(3);
        bus_read(5'h08, d); expect32("R2 pad status", d, 32'h1234_5678);
        bus_write(5'h08, 32'h0);
        bus_read(5'h08, d); expect32("R2 pad write ignored", d, 32'h1234_5678);
        pad_in = 32'h0;
        idle(4);
        bus_write(5'h18, 32'hFFFF_FFFF);

        // R3 / R5: rising on pin 20 (high register, bits 9:8)
        bus_write(5'h10, 32'h5555_5655);
        bus_write(5'h18, 32'hFFFF_FFFF);
        pad_in = 32'h0010_0000;
        idle(5);
        bus_read(5'h18, d); expect32("R5 R3 rising pin 20", d, 32'h0010_0000);
        bus_write(5'h18, 32'h0010_0000);
        idle(2);
        bus_read(5'h18, d); expect32("R5 held level no re-set", d, 32'h0);
        pad_in = 32'h0;
        idle(5);

        // R3 / R5: falling on pin 5 (low register, bits 11:10)
        bus_write(5'h0C, 32'h5555_5D55);
        bus_write(5'h18, 32'hFFFF_FFFF);
        pad_in = 32'h0000_0020;
        idle(5);
        bus_read(5'h18, d); expect32("R5 no set on rise for falling code", d, 32'h0);
        pad_in = 32'h0;
        idle(5);
        bus_read(5'h18, d); expect32("R5 R3 falling pin 5", d, 32'h0000_0020);

        // R7: masking
        expect32("R7 status set while masked, irq low", {31'b0, irq}, 32'h0);
        bus_write(5'h14, 32'h0000_0020);
        expect32("R7 irq with mask", {31'b0, irq}, 32'h1);
        bus_write(5'h14, 32'h0000_0010);
        expect32("R7 irq other mask bit", {31'b0, irq}, 32'h0);
        bus_write(5'h14, 32'h0000_0020);
        bus_write(5'h18, 32'h0000_0020);
        expect32("R7 irq after clear", {31'b0, irq}, 32'h0);

        // R9: unmapped offsets
        bus_write(5'h1C, 32'hFFFF_FFFF);
        bus_read(5'h1C, d); expect32("R9 unmapped read", d, 32'h0);
        bus_write(5'h01, 32'hDEAD_BEEF);
        bus_read(5'h00, d); expect32("R9 misaligned write ignored", d, 32'hA5A5_0F0F);
        bus_read(5'h05, d); expect32("R9 misaligned read", d, 32'h0);

        // Random traffic against the model (R1 R2 R4 R5 R6 R7 R10)
        for (int n = 0; n < 3000; n++) begin
            @(negedge clk);
            if (($urandom % 4) == 0) pad_in = $urandom;
            addr  = 5'($urandom);
            if (($urandom % 2) == 0) addr = {addr[4:2], 2'b00};
            wdata = $urandom;
            we    = (($urandom % 3) == 0);
            re    = (($urandom % 2) == 0);
        end
        @(negedge clk);
        we = 1'b0; re = 1'b0;
        idle(2);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule